// File: doc/BRIEF.md
# Slave-Port Ownership Arbiter

This block sits in front of one slave port of a multi-master interconnect and decides, cycle by cycle, which master owns that port. Every master passes a small control field taken from its address word: a priority level and a requested transfer length. The arbiter compares the levels of all current requesters. If they all match it rotates ownership fairly. If they differ it favours the most urgent level and rotates among the masters that share that level.

Ownership is granted in units that a two-bit mode input picks at runtime. The unit can be one beat, the owner's full burst, or the beat count the owner asked for in its address field. A down-counter loaded at each grant measures the unit. The lock input freezes the current decision. When nobody should drive the port, an idle flag (no-port) is raised so that the slave sees inactive control. The owner index and the idle flag both come straight from flip-flops.

Top module: `slvport_arb`

## Requirements
- R1: After reset, no_port_o is 1 and owner_o is 0.
- R2: In any cycle where lock_i is 1, the next owner_o and no_port_o equal the current ones, whatever the other inputs do.
- R3: With no_port_o at 1 and lock_i at 0, an all-zero req_i leaves no_port_o at 1. A non-zero req_i makes no_port_o 0 one cycle later, with owner_o set to a master that was requesting.
- R4: When every requester has the same level, the new owner is the first requester found by scanning upward from owner_o+1 and wrapping past NUM_MST-1.
- R5: When requester levels differ, the new owner has the numerically lowest level among requesters. Ties at that level are broken by the R4 scan order.
- R6: Each master's addr_ctl_i slice is 7 bits: bits [6:4] carry its level (address bits [28:26]) and bits [3:0] its asked length (address bits [25:22]). At a grant the ownership unit is set by unit_mode_i. Mode 0 gives 1 beat. Mode 1 gives the owner's burst_code_i beats. Mode 2 gives the asked-length beats. Mode 3 behaves like mode 0. A length code of 0 means 16 beats.
- R7: While the unit has beats left and the owner's sel_i bit is 1 with xfer_done_i at 0, the owner is kept, no_port_o stays 0, and one beat is used up per cycle.
- R8: When the unit is used up and no master other than the owner requests, the owner is kept with no_port_o at 0 if its sel_i bit is 1. Otherwise no_port_o becomes 1.
- R9: When the unit is used up and any other master requests, a new arbitration among all requesters (owner included) runs under R4/R5 and reloads the unit.
- R10: If xfer_done_i is 1, or the owner's sel_i bit drops, before the unit is used up, then no_port_o becomes 1 when req_i is zero. Otherwise a new arbitration under R4/R5 runs.
- R11: Both outputs are registered: an input change is seen at the outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_MST | Per-master request for this slave port |
| sel_i | input | NUM_MST | Per-master select of this slave (transfer in progress) |
| addr_ctl_i | input | NUM_MST*(LVL_W+LEN_W) | Per-master level and asked-length field from the address |
| burst_code_i | input | NUM_MST*LEN_W | Per-master burst beat count, 0 meaning 16 |
| unit_mode_i | input | 2 | Ownership unit: 0 beat, 1 burst, 2 asked length |
| lock_i | input | 1 | Bus lock: hold the current decision |
| xfer_done_i | input | 1 | Owner ended its transaction |
| owner_o | output | IDX_W | Index of the owning master |
| no_port_o | output | 1 | No master selected; drive the slave idle |

## Verification
Equal-level full requests check that the rotation order follows the last owner. A skewed level set with a two-way tie checks that level comes before rotation. Runs with competing requesters in each unit mode, including the 16-beat code and the spare mode, separate a one-beat hand-over from a counted hold. A lone requester with select toggled, an early end-of-transaction and a locked window each reach one branch of the release logic. Random traffic with mixed equal and unequal levels, random lock and done pulses, and mode changes then compares every cycle with a bench model.

// File: rtl/slvarb_pkg.sv
package slvarb_pkg;
   typedef enum logic [1:0] {
      UNIT_BEAT  = 2'd0,
      UNIT_BURST = 2'd1,
      UNIT_ASKED = 2'd2,
      UNIT_SPARE = 2'd3
   } unit_mode_e;
endpackage

// File: rtl/slvarb_rr_pick.sv
// Rotating pick: first candidate above last_i, else lowest candidate.
module slvarb_rr_pick #(
   parameter int NUM_MST = 4,
   parameter int IDX_W   = 2
) (
   input  logic [NUM_MST-1:0] cand_i,
   input  logic [IDX_W-1:0]   last_i,
   output logic [IDX_W-1:0]   pick_o
);
   logic [NUM_MST-1:0] up_mask;
   logic [NUM_MST-1:0] up_vec;
   logic [NUM_MST-1:0] src_vec;

   for (genvar i = 0; i < NUM_MST; i++) begin : g_mask
      assign up_mask[i] = (IDX_W'(i) > last_i);
   end

   assign up_vec  = cand_i & up_mask;
   assign src_vec = (up_vec != '0) ? up_vec : cand_i;

   always_comb begin
      pick_o = '0;
      for (int i = NUM_MST - 1; i >= 0; i--) begin
         if (src_vec[i]) pick_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/slvarb_prio_pick.sv
// Level-based pick with rotating tie break; also flags equal levels.
module slvarb_prio_pick #(
   parameter int NUM_MST      = 4,
   parameter int IDX_W        = 2,
   parameter int LVL_W        = 3,
   parameter int LOW_LVL_WINS = 1
) (
   input  logic [NUM_MST-1:0]       cand_i,
   input  logic [NUM_MST*LVL_W-1:0] lvl_i,
   input  logic [IDX_W-1:0]         last_i,
   output logic [IDX_W-1:0]         pick_o,
   output logic                     all_eq_o
);
   logic [LVL_W-1:0]   lvl_mn;
   logic [LVL_W-1:0]   lvl_mx;
   logic [LVL_W-1:0]   lvl_best;
   logic [NUM_MST-1:0] top_vec;

   always_comb begin
      lvl_mn = '1;
      lvl_mx = '0;
      for (int i = 0; i < NUM_MST; i++) begin
         if (cand_i[i]) begin
            if (lvl_i[i*LVL_W +: LVL_W] < lvl_mn) lvl_mn = lvl_i[i*LVL_W +: LVL_W];
            if (lvl_i[i*LVL_W +: LVL_W] > lvl_mx) lvl_mx = lvl_i[i*LVL_W +: LVL_W];
         end
      end
   end

   if (LOW_LVL_WINS != 0) begin : g_low
      assign lvl_best = lvl_mn;
   end else begin : g_high
      assign lvl_best = lvl_mx;
   end

   assign all_eq_o = (lvl_mn == lvl_mx);

   for (genvar i = 0; i < NUM_MST; i++) begin : g_top
      assign top_vec[i] = cand_i[i] && (lvl_i[i*LVL_W +: LVL_W] == lvl_best);
   end

   slvarb_rr_pick #(.NUM_MST(NUM_MST), .IDX_W(IDX_W)) u_tie (
      .cand_i (top_vec),
      .last_i (last_i),
      .pick_o (pick_o)
   );
endmodule

// File: rtl/slvarb_len_sel.sv
// Per-master unit length, stored as beats minus one (code 0 wraps to 16 beats).
module slvarb_len_sel
   import slvarb_pkg::*;
#(
   parameter int NUM_MST = 4,
   parameter int LEN_W   = 4
) (
   input  unit_mode_e               mode_i,
   input  logic [NUM_MST*LEN_W-1:0] burst_i,
   input  logic [NUM_MST*LEN_W-1:0] ask_i,
   output logic [NUM_MST*LEN_W-1:0] load_o
);
   for (genvar m = 0; m < NUM_MST; m++) begin : g_len
      always_comb begin
         unique case (mode_i)
            UNIT_BURST: load_o[m*LEN_W +: LEN_W] = burst_i[m*LEN_W +: LEN_W] - LEN_W'(1);
            UNIT_ASKED: load_o[m*LEN_W +: LEN_W] = ask_i[m*LEN_W +: LEN_W] - LEN_W'(1);
            default:    load_o[m*LEN_W +: LEN_W] = '0;
         endcase
      end
   end
endmodule

// File: rtl/slvport_arb.sv
module slvport_arb
   import slvarb_pkg::*;
#(
   parameter int NUM_MST      = 4,
   parameter int LVL_W        = 3,
   parameter int LEN_W        = 4,
   parameter int LOW_LVL_WINS = 1,
   localparam int IDX_W       = (NUM_MST > 1) ? $clog2(NUM_MST) : 1,
   localparam int CTL_W       = LVL_W + LEN_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_MST-1:0]       req_i,
   input  logic [NUM_MST-1:0]       sel_i,
   input  logic [NUM_MST*CTL_W-1:0] addr_ctl_i,
   input  logic [NUM_MST*LEN_W-1:0] burst_code_i,
   input  logic [1:0]               unit_mode_i,
   input  logic                     lock_i,
   input  logic                     xfer_done_i,
   output logic [IDX_W-1:0]         owner_o,
   output logic                     no_port_o
);
   if (NUM_MST < 2) begin : g_bad_mst
      $error("slvport_arb: NUM_MST must be at least 2");
   end
   if (LVL_W < 1 || LEN_W < 1) begin : g_bad_w
      $error("slvport_arb: field widths must be positive");
   end

   logic [NUM_MST*LVL_W-1:0] lvl_flat;
   logic [NUM_MST*LEN_W-1:0] ask_flat;
   logic [NUM_MST*LEN_W-1:0] load_flat;
   logic [IDX_W-1:0]         rr_idx;
   logic [IDX_W-1:0]         pr_idx;
   logic [IDX_W-1:0]         win_idx;
   logic [LEN_W-1:0]         win_load;
   logic                     lvl_eq;
   logic                     any_req;
   logic [NUM_MST-1:0]       own_oh;

   logic [IDX_W-1:0] owner_q, owner_d;
   logic             np_q, np_d;
   logic [LEN_W-1:0] cnt_q, cnt_d;

   for (genvar m = 0; m < NUM_MST; m++) begin : g_fld
      assign lvl_flat[m*LVL_W +: LVL_W] = addr_ctl_i[m*CTL_W + LEN_W +: LVL_W];
      assign ask_flat[m*LEN_W +: LEN_W] = addr_ctl_i[m*CTL_W +: LEN_W];
   end

   slvarb_rr_pick #(.NUM_MST(NUM_MST), .IDX_W(IDX_W)) u_rr (
      .cand_i (req_i),
      .last_i (owner_q),
      .pick_o (rr_idx)
   );

   slvarb_prio_pick #(
      .NUM_MST(NUM_MST), .IDX_W(IDX_W), .LVL_W(LVL_W), .LOW_LVL_WINS(LOW_LVL_WINS)
   ) u_prio (
      .cand_i   (req_i),
      .lvl_i    (lvl_flat),
      .last_i   (owner_q),
      .pick_o   (pr_idx),
      .all_eq_o (lvl_eq)
   );

   slvarb_len_sel #(.NUM_MST(NUM_MST), .LEN_W(LEN_W)) u_len (
      .mode_i  (unit_mode_e'(unit_mode_i)),
      .burst_i (burst_code_i),
      .ask_i   (ask_flat),
      .load_o  (load_flat)
   );

   assign any_req  = |req_i;
   assign own_oh   = NUM_MST'(1) << owner_q;
   assign win_idx  = lvl_eq ? rr_idx : pr_idx;
   assign win_load = load_flat[win_idx*LEN_W +: LEN_W];

   always_comb begin
      owner_d = owner_q;
      np_d    = np_q;
      cnt_d   = cnt_q;
      if (!lock_i) begin
         if (np_q) begin
            if (any_req) begin
               owner_d = win_idx;
               np_d    = 1'b0;
               cnt_d   = win_load;
            end
         end else if (cnt_q == '0) begin
            if ((req_i & ~own_oh) == '0) begin
               np_d = !sel_i[owner_q];
            end else begin
               owner_d = win_idx;
               np_d    = 1'b0;
               cnt_d   = win_load;
            end
         end else if (xfer_done_i || !sel_i[owner_q]) begin
            if (any_req) begin
               owner_d = win_idx;
               np_d    = 1'b0;
               cnt_d   = win_load;
            end else begin
               np_d = 1'b1;
            end
         end else begin
            cnt_d = cnt_q - LEN_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= '0;
         np_q    <= 1'b1;
         cnt_q   <= '0;
      end else begin
         owner_q <= owner_d;
         np_q    <= np_d;
         cnt_q   <= cnt_d;
      end
   end

   assign owner_o   = owner_q;
   assign no_port_o = np_q;
endmodule

// File: rtl/slvport_arb_chk.sv
module slvport_arb_chk #(
   parameter int NUM_MST = 4,
   parameter int IDX_W   = 2,
   parameter int CNT_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_MST-1:0] req,
   input logic [NUM_MST-1:0] sel,
   input logic               lock,
   input logic               done,
   input logic [IDX_W-1:0]   owner,
   input logic               no_port,
   input logic [CNT_W-1:0]   cnt
);
   logic [NUM_MST-1:0] req_d;
   logic [NUM_MST-1:0] own_oh;
   logic               lock_d;

   assign own_oh = NUM_MST'(1) << owner;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_d  <= '0;
         lock_d <= 1'b0;
      end else begin
         req_d  <= req;
         lock_d <= lock;
      end
   end

   assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> ($stable(owner) && $stable(no_port)));

   assert_idle_stay_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (no_port && req == '0 && !lock) |=> no_port);

   assert_idle_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (no_port && req != '0 && !lock) |=> !no_port);

   assert_grant_to_requester_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!no_port && !lock_d && ($past(no_port) || owner != $past(owner))) |-> req_d[owner]);

   assert_unit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!no_port && cnt != '0 && sel[owner] && !done && !lock) |=> (!no_port && $stable(owner)));

   assert_keep_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!no_port && cnt == '0 && (req & ~own_oh) == '0 && sel[owner] && !lock)
      |=> (!no_port && $stable(owner)));

   assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!no_port && cnt == '0 && req == '0 && !sel[owner] && !lock) |=> no_port);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!no_port && cnt != '0 && done && req == '0 && !lock) |=> no_port);
endmodule

bind slvport_arb slvport_arb_chk #(.NUM_MST(NUM_MST), .IDX_W(IDX_W), .CNT_W(LEN_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req     (req_i),
   .sel     (sel_i),
   .lock    (lock_i),
   .done    (xfer_done_i),
   .owner   (owner_q),
   .no_port (np_q),
   .cnt     (cnt_q)
);

// File: tb/slvport_arb_test.sv
`timescale 1ns/1ps
module slvport_arb_test;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] sel = '0;
   logic [N*7-1:0] addr_ctl;
   logic [N*4-1:0] burst_code;
   logic [1:0]   mode = 2'd0;
   logic         lock = 1'b0;
   logic         done = 1'b0;
   logic [1:0]   owner;
   logic         no_port;

   logic [2:0] lv [N];
   logic [3:0] ak [N];
   logic [3:0] bc [N];

   for (genvar m = 0; m < N; m++) begin : g_pack
      assign addr_ctl[m*7 +: 7]   = {lv[m], ak[m]};
      assign burst_code[m*4 +: 4] = bc[m];
   end

   always #2.5 clk = ~clk;

   slvport_arb uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .sel_i(sel), .addr_ctl_i(addr_ctl),
      .burst_code_i(burst_code), .unit_mode_i(mode), .lock_i(lock),
      .xfer_done_i(done), .owner_o(owner), .no_port_o(no_port)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int m_own = 0;
   bit m_np  = 1'b1;
   int m_cnt = 0;

   function automatic int pick(input logic [N-1:0] c, input int last);
      int best = 8;
      for (int i = 0; i < N; i++) if (c[i] && lv[i] < best) best = lv[i];
      for (int k = 1; k <= N; k++) begin
         int idx = (last + k) % N;
         if (c[idx] && lv[idx] == best) return idx;
      end
      return 0;
   endfunction

   function automatic int beats(input int idx);
      int code;
      if (mode == 2'd1) code = bc[idx];
      else if (mode == 2'd2) code = ak[idx];
      else return 1;
      return (code == 0) ? 16 : code;
   endfunction

   task automatic grant();
      m_own = pick(req, m_own);
      m_np  = 1'b0;
      m_cnt = beats(m_own) - 1;
   endtask

   task automatic model_step();
      logic [N-1:0] others;
      others = req & ~(N'(1) << m_own);
      if (lock) begin
      end else if (m_np) begin
         if (req != '0) grant();
      end else if (m_cnt == 0) begin
         if (others == '0) m_np = !sel[m_own];
         else grant();
      end else if (done || !sel[m_own]) begin
         if (req != '0) grant();
         else m_np = 1'b1;
      end else begin
         m_cnt = m_cnt - 1;
      end
   endtask

   task automatic check(input string tag, input int got_o, input bit got_np,
                        input int exp_o, input bit exp_np);
      n_checks++;
      if (got_o != exp_o || got_np != exp_np) begin
         n_fail++;
         $display("FAIL %s owner=%0d no_port=%0d expected owner=%0d no_port=%0d",
                  tag, got_o, got_np, exp_o, exp_np);
      end
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(tag, owner, no_port, m_own, m_np);
   endtask

   task automatic set_lv(input int a, input int b, input int c, input int d);
      lv[0] = 3'(a); lv[1] = 3'(b); lv[2] = 3'(c); lv[3] = 3'(d);
   endtask

   initial begin
      int exp_rr[5] = '{1, 2, 3, 0, 1};
      int exp_pr[4] = '{3, 1, 3, 1};
      int snap_o;
      bit snap_np;
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin
         lv[i] = 3'd2; ak[i] = 4'd1; bc[i] = 4'd1;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state", owner, no_port, 0, 1'b1);

      // R11: request seen only after the next edge
      req = 4'b1111; sel = 4'b1111;
      #1;
      check("R11 registered output", owner, no_port, 0, 1'b1);

      // R4: equal levels rotate
      for (int k = 0; k < 5; k++) begin
         tick("R4 rotation");
         check("R4 explicit order", owner, no_port, exp_rr[k], 1'b0);
      end

      // R5: lowest level wins, tie rotates
      set_lv(3, 1, 5, 1);
      for (int k = 0; k < 4; k++) begin
         tick("R5 priority");
         check("R5 explicit order", owner, no_port, exp_pr[k], 1'b0);
      end

      // R6/R9: unit modes with competing equal-level requesters
      set_lv(4, 4, 4, 4);
      req = 4'b0011; sel = 4'b0011;
      mode = 2'd1; bc[0] = 4'd2; bc[1] = 4'd3;
      repeat (20) tick("R6 burst unit");
      mode = 2'd2; ak[0] = 4'd0; ak[1] = 4'd5;
      repeat (45) tick("R7 asked unit hold");
      mode = 2'd3;
      repeat (8) tick("R9 spare mode one beat");

      // R8: lone requester kept, released when select drops
      mode = 2'd0; req = 4'b0000; sel = 4'b0000;
      repeat (3) tick("R8 release");
      check("R8 idle after release", 0, no_port, 0, 1'b1);
      req = 4'b0001; sel = 4'b0001;
      repeat (4) tick("R8 keep alone");
      check("R8 explicit keep", owner, no_port, 0, 1'b0);
      req = 4'b0000; sel = 4'b0000;
      tick("R8 select low");
      check("R8 explicit idle", 0, no_port, 0, 1'b1);

      // R10: early end of transaction
      mode = 2'd2; ak[0] = 4'd8; ak[1] = 4'd8;
      req = 4'b0011; sel = 4'b0011;
      repeat (3) tick("R10 setup");
      done = 1'b1;
      tick("R10 done rearbitrate");
      done = 1'b0;
      repeat (2) tick("R10 hold");
      req = 4'b0000; done = 1'b1;
      tick("R10 done idle");
      check("R10 explicit idle", 0, no_port, 0, 1'b1);
      done = 1'b0;

      // R2: lock freezes decision
      req = 4'b1010; sel = 4'b1010; mode = 2'd0;
      repeat (2) tick("R2 setup");
      snap_o = owner; snap_np = no_port;
      lock = 1'b1;
      for (int k = 0; k < 6; k++) begin
         req = 4'($urandom); sel = 4'($urandom); done = 1'($urandom);
         tick("R2 lock");
         check("R2 explicit frozen", owner, no_port, snap_o, snap_np);
      end
      lock = 1'b0; done = 1'b0;

      // Random traffic
      for (int c = 0; c < 4000; c++) begin
         bit eq;
         if (c % 64 == 0) mode = 2'($urandom);
         eq = 1'($urandom);
         for (int i = 0; i < N; i++) begin
            if ((c % 16) == 0) begin
               lv[i] = eq ? 3'd3 : 3'($urandom_range(0, 3));
               ak[i] = 4'($urandom);
               bc[i] = 4'($urandom);
            end
         end
         req  = 4'($urandom);
         sel  = req | 4'($urandom);
         lock = ($urandom_range(0, 15) == 0);
         done = ($urandom_range(0, 7) == 0);
         tick("R9 random model");
      end
      lock = 1'b0; done = 1'b0;

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired owner=%0d expected run to end", owner);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule